// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a 512-word by 18-bit FIFO that sits between two clock domains. The producer and the consumer may run on unrelated clocks or on one shared clock. The producer writes through a pair of enables of opposite polarity and is paced by an input-ready flag that lives in its own clock domain. The consumer sees the oldest stored word already present in an output register. An output-ready flag, timed by the read clock, marks that word as valid. The consumer takes the word by pulling three active-low qualifiers low together.

The first word that lands in an empty FIFO moves to the output register without any read request. When a word is taken and more are stored, the next word replaces it on the same read edge, so a consumer that holds its qualifiers low drains one word per edge.

Two status flags are timed by the write clock. Half-full marks an occupancy above half the depth. The edge flag warns that the FIFO is nearly empty or nearly full, using an offset that the producer can program. Occupancy always counts the word held in the output register.

Reset is asynchronous and active low. It clears the pointers, the synchronizers and the flags in both domains.

Top module: `fallthru_fifo`

## Requirements
- R1: The FIFO holds at most 512 words. `inReady` goes low once 512 words are held, and no word is accepted while it is low.
- R2: A word is stored on a rising `wrClk` edge only when `wrEn` is 1, `wrEnN` is 0, `progN` is 1 and `inReady` is 1. With any other level of the two enables, nothing is stored.
- R3: A word is consumed on a rising `rdClk` edge only when `rdEnN`, `oeAN` and `oeBN` are all 0 and `outReady` is 1. If any one of the three qualifiers is 1, `rdData` and `outReady` hold their values.
- R4: When a word reaches an empty FIFO, it appears on `rdData` with `outReady` high without any read request, whatever the levels of the qualifiers.
- R5: Words leave the FIFO in the order in which they were accepted, with their values unchanged.
- R6: `outReady` is high only while `rdData` carries a stored, unconsumed word. It falls on the edge that consumes the last word when no further word is stored.
- R7: While `rstN` is low, `inReady`, `outReady` and `halfFull` are 0 and `edgeFlag` is 1. Reset needs no clock to take effect. `inReady` rises within a few write-clock edges after release.
- R8: `halfFull` is 1 when the occupancy, counting the word in the output register, is 257 or more, and 0 otherwise.
- R9: A `wrClk` edge with `progN` low loads the edge offset from `wrData[8:0]` and stores no word. After reset the offset is 64.
- R10: `edgeFlag` is 1 when the occupancy is at or below the offset, or at or above 512 minus the offset, and 0 otherwise.
- R11: With the qualifiers held low and words stored, one word is consumed on every read edge, with no idle edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous reset, active low, for both domains |
| wrClk | input | 1 | Write clock |
| wrEn | input | 1 | Write enable, active high |
| wrEnN | input | 1 | Write enable, active low |
| progN | input | 1 | Loads the edge offset from `wrData[8:0]` when low |
| wrData | input | 18 | Write data |
| inReady | output | 1 | FIFO can accept a word (write domain) |
| rdClk | input | 1 | Read clock |
| rdEnN | input | 1 | Read enable, active low |
| oeAN | input | 1 | First read qualifier, active low |
| oeBN | input | 1 | Second read qualifier, active low |
| rdData | output | 18 | Output register holding the oldest word |
| outReady | output | 1 | `rdData` is valid (read domain) |
| halfFull | output | 1 | Occupancy of 257 or more (write domain) |
| edgeFlag | output | 1 | Occupancy within the offset of empty or of full (write domain) |

## Verification
A slow fill with pauses at the flag thresholds separates off-by-one errors in the half-full and edge comparisons. It also shows whether the output-register word is counted. A full burst drain with the qualifiers held low tells a same-edge reload apart from a reload that costs an edge. Sweeping each qualifier high on its own shows whether every qualifier gates the read. A long random mix of write enables and qualifiers, checked against an ordered model, exposes lost, duplicated or reordered words near full and near empty.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic wrStrobe;  // store wrData at wrAddr (write domain)
    logic offLoad;   // load edge offset from wrData (write domain)
    logic memLoad;   // copy mem[rdAddr] into the output register (read domain)
  } strobeT;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  function automatic logic [W-1:0] grayToBin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign binOut = grayToBin(stage2);
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifoPkg::*;
#(
  parameter int AW = 9
) (
  input  logic          rstN,
  input  logic          wrClk,
  input  logic          wrEn,
  input  logic          wrEnN,
  input  logic          progN,
  input  logic [AW-1:0] offset,
  output logic          inReady,
  output logic          halfFull,
  output logic          edgeFlag,
  output logic [AW-1:0] wrAddr,
  input  logic          rdClk,
  input  logic          rdEnN,
  input  logic          oeAN,
  input  logic          oeBN,
  output logic          outReady,
  output logic [AW-1:0] rdAddr,
  output strobeT        st
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2 + 1);

  function automatic logic [PW-1:0] binToGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, relBinW, wrOcc, wrBinNext, occNext, offExt;
  logic          wrAccept;

  assign wrAccept  = wrEn & ~wrEnN & progN & inReady;
  assign wrBinNext = wrBin + PW'(wrAccept);
  assign wrOcc     = wrBin - relBinW;
  assign occNext   = wrBinNext - relBinW;
  assign offExt    = {1'b0, offset};

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      inReady  <= 1'b0;
      halfFull <= 1'b0;
      edgeFlag <= 1'b1;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= binToGray(wrBinNext);
      inReady  <= (occNext != DEPTH_P);
      halfFull <= (occNext >= HALF_P);
      edgeFlag <= (occNext <= offExt) || (occNext >= DEPTH_P - offExt);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, relBin, relGray, wrBinR, relBinNext;
  logic          outValid, rdReq, memEmpty, memLoad;

  assign rdReq      = outValid & ~rdEnN & ~oeAN & ~oeBN;
  assign memEmpty   = (rdBin == wrBinR);
  assign memLoad    = (~outValid | rdReq) & ~memEmpty;
  assign relBinNext = relBin + PW'(rdReq);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      relBin   <= '0;
      relGray  <= '0;
      outValid <= 1'b0;
    end else begin
      rdBin    <= rdBin + PW'(memLoad);
      relBin   <= relBinNext;
      relGray  <= binToGray(relBinNext);
      outValid <= memLoad | (outValid & ~rdReq);
    end
  end

  // ---------------- crossings ----------------
  gray_sync #(.W(PW)) i_relSync (
    .clk(wrClk), .rstN(rstN), .grayIn(relGray), .binOut(relBinW)
  );
  gray_sync #(.W(PW)) i_wrSync (
    .clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(wrBinR)
  );

  assign wrAddr      = wrBin[AW-1:0];
  assign rdAddr      = rdBin[AW-1:0];
  assign outReady    = outValid;
  assign st.wrStrobe = wrAccept;
  assign st.offLoad  = ~progN;
  assign st.memLoad  = memLoad;

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    wrAccept |-> (wrOcc < DEPTH_P)); // R1
  AST_FWFT_LOAD: assert property (@(posedge rdClk) disable iff (!rstN)
    (!outValid && !memEmpty) |=> outValid); // R4
  AST_QUAL_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (outValid && (rdEnN || oeAN || oeBN)) |=> outValid); // R3
  AST_EMPTY_DROP: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdReq && memEmpty) |=> !outValid); // R6
endmodule

// File: rtl/fifo_dp.sv
module fifo_dp
  import fifoPkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int AW      = 9,
  parameter int DEF_OFF = 64
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  strobeT            st,
  output logic [AW-1:0]     offset,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (st.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) offset <= AW'(DEF_OFF);
    else if (st.offLoad) offset <= wrData[AW-1:0];
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (st.memLoad) rdData <= mem[rdAddr];
  end

  AST_PROG_NO_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    !(st.offLoad && st.wrStrobe)); // R9
endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import fifoPkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int AW      = 9,
  parameter int DEF_OFF = 64
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic              wrEnN,
  input  logic              progN,
  input  logic [DATA_W-1:0] wrData,
  output logic              inReady,
  input  logic              rdClk,
  input  logic              rdEnN,
  input  logic              oeAN,
  input  logic              oeBN,
  output logic [DATA_W-1:0] rdData,
  output logic              outReady,
  output logic              halfFull,
  output logic              edgeFlag
);
  strobeT        st;
  logic [AW-1:0] wrAddr, rdAddr, offset;

  fifo_ctrl #(.AW(AW)) i_ctrl (
    .rstN(rstN), .wrClk(wrClk), .wrEn(wrEn), .wrEnN(wrEnN), .progN(progN),
    .offset(offset), .inReady(inReady), .halfFull(halfFull),
    .edgeFlag(edgeFlag), .wrAddr(wrAddr), .rdClk(rdClk), .rdEnN(rdEnN),
    .oeAN(oeAN), .oeBN(oeBN), .outReady(outReady), .rdAddr(rdAddr), .st(st)
  );

  fifo_dp #(.DATA_W(DATA_W), .AW(AW), .DEF_OFF(DEF_OFF)) i_dp (
    .rstN(rstN), .wrClk(wrClk), .rdClk(rdClk), .wrData(wrData),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .st(st), .offset(offset), .rdData(rdData)
  );

  AST_OUT_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (outReady && (rdEnN || oeAN || oeBN)) |=> (outReady && $stable(rdData))); // R3
endmodule

// File: tb/test_fallthru_fifo.sv
module test_fallthru_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrEnN = 1'b1, progN = 1'b1;
  logic [17:0] wrData = '0;
  logic rdEnN = 1'b1, oeAN = 1'b1, oeBN = 1'b1;
  logic inReady, outReady, halfFull, edgeFlag;
  logic [17:0] rdData;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [17:0] model[$];
  logic [17:0] seqData = 18'h00100;

  always #2 clk = ~clk;

  fallthru_fifo i_fallthru_fifo (
    .rstN(rstN), .wrClk(clk), .wrEn(wrEn), .wrEnN(wrEnN), .progN(progN),
    .wrData(wrData), .inReady(inReady), .rdClk(clk), .rdEnN(rdEnN),
    .oeAN(oeAN), .oeBN(oeBN), .rdData(rdData), .outReady(outReady),
    .halfFull(halfFull), .edgeFlag(edgeFlag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply the inputs set now at the next edge; update the model from outputs
  // sampled before that edge.
  task automatic tick();
    if (wrEn && !wrEnN && progN && inReady) model.push_back(wrData);
    if (outReady && !rdEnN && !oeAN && !oeBN) begin
      if (model.size() == 0) chk(1'b0, "R6 read with nothing stored", 1, 0);
      else begin
        chk(rdData == model[0], "R5 data order", 32'(rdData), 32'(model[0]));
        void'(model.pop_front());
      end
    end else if (outReady) begin
      chk(model.size() != 0, "R6 valid without stored word", 0, 1);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wrEn = 1'b0; wrEnN = 1'b1; progN = 1'b1;
    repeat (n) tick();
  endtask

  task automatic fillTo(input int target);
    while (model.size() < target) begin
      wrEn = 1'b1; wrEnN = 1'b0; progN = 1'b1; wrData = seqData;
      tick();
      seqData = seqData + 18'd1;
    end
    idle(6);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rdEnN = 1'b1; oeAN = 1'b1; oeBN = 1'b1;
    wrEn = 1'b0; wrEnN = 1'b1; progN = 1'b1;
    model.delete();
    repeat (6) @(negedge clk);
    chk(!inReady, "R7 inReady in reset", 32'(inReady), 0);
    chk(!outReady, "R7 outReady in reset", 32'(outReady), 0);
    chk(!halfFull, "R7 halfFull in reset", 32'(halfFull), 0);
    chk(edgeFlag, "R7 edgeFlag in reset", 32'(edgeFlag), 1);
    rstN = 1'b1;
    idle(4);
    chk(inReady, "R7 inReady after release", 32'(inReady), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    // R2: disabled enable combinations store nothing
    wrEn = 1'b0; wrEnN = 1'b0; wrData = 18'h3AAAA;
    repeat (3) tick();
    wrEn = 1'b1; wrEnN = 1'b1; wrData = 18'h15555;
    repeat (3) tick();
    idle(6);
    chk(!outReady, "R2 disabled writes stored nothing", 32'(outReady), 0);

    // R9: program offset 10 with enables active; no word stored
    wrEn = 1'b1; wrEnN = 1'b0; progN = 1'b0; wrData = 18'd10;
    @(negedge clk);
    idle(6);
    chk(!outReady, "R9 program cycle stored no word", 32'(outReady), 0);
    fillTo(10);
    chk(edgeFlag, "R10 occupancy 10 at offset 10", 32'(edgeFlag), 1);
    // R4: word falls through with qualifiers high
    chk(outReady && rdData == model[0], "R4 fall-through", 32'(rdData), 32'(model[0]));
    fillTo(11);
    chk(!edgeFlag, "R10 occupancy 11 above offset 10", 32'(edgeFlag), 0);

    // R3: each qualifier alone blocks the read
    for (int k = 0; k < 3; k++) begin
      rdEnN = (k == 0); oeAN = (k == 1); oeBN = (k == 2);
      repeat (3) tick();
      chk(outReady && rdData == model[0] && model.size() == 11,
          "R3 qualifier blocks read", 32'(model.size()), 11);
    end
    // R11: single read replaces the word on the same edge
    rdEnN = 1'b0; oeAN = 1'b0; oeBN = 1'b0;
    tick();
    rdEnN = 1'b1;
    chk(outReady && rdData == model[0], "R11 next word after one read",
        32'(rdData), 32'(model[0]));

    // Default offset, half-full and full
    doReset();
    fillTo(64);
    chk(edgeFlag, "R9 default offset 64: occupancy 64", 32'(edgeFlag), 1);
    fillTo(65);
    chk(!edgeFlag, "R10 occupancy 65", 32'(edgeFlag), 0);
    fillTo(256);
    chk(!halfFull, "R8 occupancy 256", 32'(halfFull), 0);
    fillTo(257);
    chk(halfFull, "R8 occupancy 257", 32'(halfFull), 1);
    fillTo(447);
    chk(!edgeFlag, "R10 occupancy 447", 32'(edgeFlag), 0);
    fillTo(448);
    chk(edgeFlag, "R10 occupancy 448", 32'(edgeFlag), 1);
    fillTo(512);
    chk(!inReady, "R1 inReady low at 512", 32'(inReady), 0);
    wrEn = 1'b1; wrEnN = 1'b0; wrData = 18'h3FFFF;
    repeat (8) tick();
    idle(2);
    chk(model.size() == 512 && !inReady, "R1 no write while full",
        32'(model.size()), 512);

    // R11: back-to-back drain of 512 words
    rdEnN = 1'b0; oeAN = 1'b0; oeBN = 1'b0;
    for (int i = 0; i < 512; i++) begin
      if (!outReady) chk(1'b0, "R11 gap in back-to-back read", i, 512);
      tick();
    end
    chk(!outReady && model.size() == 0, "R6 outReady drops after last word",
        32'(outReady), 0);
    idle(6);
    chk(edgeFlag && !halfFull, "R10 empty after drain", 32'(edgeFlag), 1);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      wrEn  = (i < 3000) ? ($urandom % 5 != 0) : ($urandom % 3 == 0);
      wrEnN = ($urandom % 8 == 0);
      progN = 1'b1;
      wrData = 18'($urandom);
      rdEnN = (i < 3000) ? ($urandom % 2 == 0) : ($urandom % 5 == 0);
      oeAN  = ($urandom % 8 == 0);
      oeBN  = ($urandom % 8 == 0);
      tick();
    end
    rdEnN = 1'b0; oeAN = 1'b0; oeBN = 1'b0;
    idle(600);
    chk(!outReady && model.size() == 0, "R5 random mix fully drained",
        32'(model.size()), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule